// File: doc/BRIEF.md
# Universal Bidirectional-Port Shift Register

An eight-stage register with four operating modes, picked each clock by a two-bit mode select: hold, shift toward the high end, shift toward the low end, and parallel load. The stages are called A (bit 0) through H (bit 7). A single set of eight parallel terminals serves as both the load input and the parallel output. For synthesis each terminal is split into a data-in bit, a data-out bit and one shared output-enable. Two active-low enables gate the parallel drivers. Load mode also releases the drivers, so that an external source can present the data to be captured.

Two serial inputs feed the end stages. The low-end input enters at stage A during a shift toward H. The high-end input enters at stage H during a shift toward A. Two serial outputs show stages A and H at all times. An active-low clear empties the register at once, without waiting for a clock edge, and overrides every mode.

Top module: `ushift_reg`

## Requirements
- R1: While `clr_n` is low, all stages read zero at once, without a clock edge. Rising clock edges during that time leave the stages at zero in every mode.
- R2: With `mode_sel` = 2'b00 (hold), a rising edge leaves every stage unchanged.
- R3: With `mode_sel` = 2'b01 (shift toward H), a rising edge loads `ser_in_lo` into stage A (bit 0), and each stage i > 0 takes the old value of stage i-1.
- R4: With `mode_sel` = 2'b10 (shift toward A), a rising edge loads `ser_in_hi` into stage H (bit 7), and each stage i < 7 takes the old value of stage i+1.
- R5: With `mode_sel` = 2'b11 (load), a rising edge captures `pdata_in` into the stages, bit for bit.
- R6: `pdata_oe` is 1 only when `oen_a` and `oen_b` are both 0 and `mode_sel` is not 2'b11. While `pdata_oe` is 0, `pdata_out` is all zeros. While it is 1, `pdata_out` equals the stages.
- R7: The enables have no effect on the stage contents. Shifting, loading, holding and clearing proceed the same with either enable high.
- R8: `ser_out_a` always equals stage A and `ser_out_h` always equals stage H, whatever the enables are.
- R9: While `clr_n` is low, both enables are low and the mode is not load, `pdata_oe` is 1 and `pdata_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Mode: 00 hold, 01 shift to H, 10 shift to A, 11 load |
| ser_in_lo | input | 1 | Serial data entering stage A when shifting toward H |
| ser_in_hi | input | 1 | Serial data entering stage H when shifting toward A |
| oen_a | input | 1 | Parallel driver enable, active low |
| oen_b | input | 1 | Parallel driver enable, active low |
| pdata_in | input | 8 | Parallel terminal input side, captured in load mode |
| pdata_out | output | 8 | Parallel terminal output side |
| pdata_oe | output | 1 | Drive enable for all eight parallel terminals |
| ser_out_a | output | 1 | Stage A, always driven |
| ser_out_h | output | 1 | Stage H, always driven |

## Verification
The clocked properties assume that `clr_n` changes away from the rising clock edge, so that at each edge the register is either fully cleared or fully in the selected mode. They also assume that `mode_sel` and the serial and parallel inputs are settled at the edge. The bench changes every input, including clear, only on falling edges or a short delay after them. This keeps each sampled edge free of races. The mid-cycle clear test lowers `clr_n` between edges, which exercises the asynchronous path without violating these assumptions.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    localparam int unsigned STAGES = 8;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  drive_en;
    } ctrl_t;

    function automatic logic both_enabled(input logic en_a_n, input logic en_b_n);
        return !(en_a_n || en_b_n);
    endfunction

endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
    import ushift_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       en_a_n,
    input  logic       en_b_n,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl.mode     = mode_e'(sel);
        ctrl.drive_en = both_enabled(en_a_n, en_b_n) && (ctrl.mode != MODE_LOAD);
    end
endmodule

// File: rtl/ushift_core.sv
module ushift_core
    import ushift_pkg::*;
#(
    parameter int unsigned W = STAGES
) (
    input  logic         clk,
    input  logic         clr_n,
    input  mode_e        mode,
    input  logic         sin_lo,
    input  logic         sin_hi,
    input  logic [W-1:0] pin,
    output logic [W-1:0] q
);
    localparam int unsigned TOP = W - 1;

    logic [W-1:0] from_below;
    logic [W-1:0] from_above;
    logic [W-1:0] q_next;

    // Neighbour selection per stage; the end stages take the serial inputs.
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_lo_end
            assign from_below[i] = sin_lo;
        end else begin : g_lo_mid
            assign from_below[i] = q[i-1];
        end
        if (i == TOP) begin : g_hi_end
            assign from_above[i] = sin_hi;
        end else begin : g_hi_mid
            assign from_above[i] = q[i+1];
        end

        always_comb begin
            unique case (mode)
                MODE_SHR:  q_next[i] = from_below[i];
                MODE_SHL:  q_next[i] = from_above[i];
                MODE_LOAD: q_next[i] = pin[i];
                default:   q_next[i] = q[i];
            endcase
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= q_next;
    end

    p_clear_r1: assert property (@(posedge clk) !clr_n |-> (q == '0))
        else $error("clear did not empty register");
    p_hold_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_HOLD) |=> $stable(q))
        else $error("hold changed register");
    p_shr_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_SHR) |=> (q == {$past(q[TOP-1:0]), $past(sin_lo)}))
        else $error("shift toward H wrong");
    p_shl_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_SHL) |=> (q == {$past(sin_hi), $past(q[TOP:1])}))
        else $error("shift toward A wrong");
    p_load_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_LOAD) |=> (q == $past(pin)))
        else $error("load wrong");
endmodule

// File: rtl/ushift_drv.sv
module ushift_drv #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] q,
    input  logic         drive_en,
    output logic [W-1:0] dout,
    output logic         oe
);
    assign oe   = drive_en;
    assign dout = drive_en ? q : '0;
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
(
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode_sel,
    input  logic             ser_in_lo,
    input  logic             ser_in_hi,
    input  logic             oen_a,
    input  logic             oen_b,
    input  logic [STAGES-1:0] pdata_in,
    output logic [STAGES-1:0] pdata_out,
    output logic             pdata_oe,
    output logic             ser_out_a,
    output logic             ser_out_h
);
    ctrl_t             ctrl;
    logic [STAGES-1:0] stages;

    ushift_ctrl u_ctrl (
        .sel    (mode_sel),
        .en_a_n (oen_a),
        .en_b_n (oen_b),
        .ctrl   (ctrl)
    );

    ushift_core #(.W(STAGES)) u_core (
        .clk    (clk),
        .clr_n  (clr_n),
        .mode   (ctrl.mode),
        .sin_lo (ser_in_lo),
        .sin_hi (ser_in_hi),
        .pin    (pdata_in),
        .q      (stages)
    );

    ushift_drv #(.W(STAGES)) u_drv (
        .q        (stages),
        .drive_en (ctrl.drive_en),
        .dout     (pdata_out),
        .oe       (pdata_oe)
    );

    assign ser_out_a = stages[0];
    assign ser_out_h = stages[STAGES-1];

    // Port-level gating check (R6): any high enable or load mode releases the drivers.
    p_gate_r6: assert property (@(posedge clk)
        (oen_a || oen_b || (mode_sel == 2'b11)) |-> (!pdata_oe && (pdata_out == '0)))
        else $error("parallel drivers active when released");
    p_clrout_r9: assert property (@(posedge clk)
        (!clr_n && !oen_a && !oen_b && (mode_sel != 2'b11)) |-> (pdata_oe && (pdata_out == '0)))
        else $error("clear did not drive zeros");
endmodule

// File: tb/ushift_reg_test.sv
module ushift_reg_test;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       ser_in_lo = 1'b0, ser_in_hi = 1'b0;
    logic       oen_a = 1'b0, oen_b = 1'b0;
    logic [7:0] pdata_in = 8'h00;
    logic [7:0] pdata_out;
    logic       pdata_oe, ser_out_a, ser_out_h;

    int checks = 0;
    int failures = 0;
    logic [7:0] ref_q = 8'h00;

    always #2.5 clk = ~clk;

    ushift_reg uut (
        .clk(clk), .clr_n(clr_n), .mode_sel(mode_sel),
        .ser_in_lo(ser_in_lo), .ser_in_hi(ser_in_hi),
        .oen_a(oen_a), .oen_b(oen_b), .pdata_in(pdata_in),
        .pdata_out(pdata_out), .pdata_oe(pdata_oe),
        .ser_out_a(ser_out_a), .ser_out_h(ser_out_h)
    );

    // Vector fields: [13:12] mode, [11] ser_in_lo, [10] ser_in_hi, [9] oen_a, [8] oen_b, [7:0] pdata_in
    localparam logic [13:0] VEC [14] = '{
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF},
        {2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C},
        {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81},
        {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h55},
        {2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01},
        {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_outs(input string req);
        logic exp_oe;
        exp_oe = !oen_a && !oen_b && (mode_sel != 2'b11);
        chk({req, "/R6 oe"}, {31'd0, pdata_oe}, {31'd0, exp_oe});
        chk({req, "/R6 pout"}, {24'd0, pdata_out}, {24'd0, exp_oe ? ref_q : 8'h00});
        chk({req, "/R8 a"}, {31'd0, ser_out_a}, {31'd0, ref_q[0]});
        chk({req, "/R8 h"}, {31'd0, ser_out_h}, {31'd0, ref_q[7]});
    endtask

    task automatic cycle(input logic [13:0] v);
        @(negedge clk);
        mode_sel = v[13:12]; ser_in_lo = v[11]; ser_in_hi = v[10];
        oen_a = v[9]; oen_b = v[8]; pdata_in = v[7:0];
        #1;
        check_outs("pre");
        @(posedge clk);
        if (clr_n) begin
            case (v[13:12])
                2'b01:   ref_q = {ref_q[6:0], v[11]};
                2'b10:   ref_q = {v[10], ref_q[7:1]};
                2'b11:   ref_q = v[7:0];
                default: ref_q = ref_q;
            endcase
        end else ref_q = 8'h00;
        #1;
        check_outs({mode_req(v[13:12]), "/R7"});
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1/R9: reset state with clear held low and enables low
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset", {24'd0, pdata_out}, 32'd0);
        chk("R9 clear oe", {31'd0, pdata_oe}, 32'd1);
        @(negedge clk);
        clr_n = 1'b1;

        for (int i = 0; i < 14; i++) cycle(VEC[i]);

        // R1: asynchronous clear mid-cycle, after loading a nonzero value
        cycle({2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0});
        cycle({2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00});
        @(negedge clk);
        #1 clr_n = 1'b0;
        #0.5;
        ref_q = 8'h00;
        chk("R1 async", {24'd0, pdata_out}, 32'd0);
        chk("R9 async oe", {31'd0, pdata_oe}, 32'd1);
        chk("R1 serial h", {31'd0, ser_out_h}, 32'd0);
        // R1: clock edges in load and shift modes have no effect while clear is low
        cycle({2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF});
        cycle({2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF});
        cycle({2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF});
        chk("R1 held zero", {31'd0, ser_out_a}, 32'd0);
        @(negedge clk);
        clr_n = 1'b1;

        // R7: fill the register with both enables high, then read it back enabled
        cycle({2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00});
        cycle({2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00});
        cycle({2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00});
        chk("R7 readback", {24'd0, pdata_out}, 32'h03);

        // Random mixes over all modes and enable combinations
        for (int n = 0; n < 300; n++) cycle(14'($urandom));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule